// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Handover

The block moves a programmed number of words between one peripheral and memory without the processor taking part in each word. The processor first sets a start address, a word count and a control word through a small register port. That port only works while the processor owns the buses (bus grant low). Setting the start bit arms the transfer. The engine then raises a bus request and waits for the grant. While it holds the grant, it drives the memory address and a read or write strobe for each word.

The peripheral side works as a stream. `dma_req` is the peripheral's valid (when it supplies data) or its ready (when it takes data). `dma_ack` is the engine's matching half of the handshake. A word moves in exactly the cycles where both are high. `dma_ack` never rises unless `dma_req` is high. A peripheral that supplies data must hold `per_wdata` stable while `dma_req` is high and `dma_ack` is low. A peripheral that takes data may lower `dma_req` at any time to apply back-pressure; no word moves in that cycle.

Memory answers reads in the same cycle (`mem_rdata` follows `mem_addr` combinationally) and commits writes at the clock edge. Two bus modes are provided. In burst mode the whole block moves in one tenure. In cycle-stealing mode the bus is handed back after every word. Completion raises `irq` and holds it until software clears it.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `bus_req`, `irq`, `dma_ack`, `mem_rd` and `mem_wr` are 0, and register selects 0 (address), 1 (count) and 2 (control) all read 0.
- R2: A register write takes effect only when `cpu_sel` and `cpu_wr` are high and `bus_grant` is 0. While `bus_grant` is 1, writes are dropped and `cpu_rdata` reads 0.
- R3: Writing control bit 0 (start) with a nonzero count raises `bus_req` in the next cycle. No strobe and no `dma_ack` appear while `bus_grant` stays 0.
- R4: A word moves in a cycle where the engine holds the bus, `bus_grant` is 1 and `dma_req` is 1. In that cycle `dma_ack` is 1 and `mem_addr` equals the address register. With control bit 1 = 1, the word goes from peripheral to memory: `mem_wr` is 1 and `mem_wdata` = `per_wdata`. With control bit 1 = 0, the word goes from memory to peripheral: `mem_rd` is 1 and `per_rdata` = `mem_rdata`.
- R5: After each word the address register increments by one and the count register decrements by one. Both are readable once the bus is returned.
- R6: Burst mode (control bit 2 = 0) keeps `bus_req` high without a break from the start until the last word.
- R7: Cycle-stealing mode (control bit 2 = 1) lowers `bus_req` in the cycle after every word. It raises `bus_req` again only after it has seen `bus_grant` low.
- R8: In the cycle after the last word, `bus_req` is 0 and `irq` is 1.
- R9: A start with count 0 sets `irq` in the next cycle and never raises `bus_req`.
- R10: `irq` (control read bit 3, done) stays set until a permitted control write with bit 3 = 1. While a transfer is in progress, writes to address, count, direction, mode and start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register port select |
| cpu_wr | input | 1 | Register port write enable |
| cpu_rsel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data (0 while granted) |
| bus_req | output | 1 | Request for the shared buses |
| bus_grant | input | 1 | Buses handed to the engine |
| mem_addr | output | ADDR_W | Memory address (0 unless granted) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| dma_req | input | 1 | Peripheral valid/ready |
| dma_ack | output | 1 | Word moves this cycle |
| per_wdata | input | DATA_W | Word from the peripheral |
| per_rdata | output | DATA_W | Word to the peripheral |
| irq | output | 1 | Block done |

## Verification
A processor write to the address register can arrive in the very cycle in which the engine moves a word and increments the same register. The bench waits for a cycle with `dma_ack` high in a burst and puts the write on the port in that same cycle. When the block is finished, the address must read as start plus the word count, with the processor's value nowhere. A second collision comes in cycle-stealing mode. There, a count write lands during the gap where the grant is low but the block is still in progress. The transfer must still move exactly its programmed number of words.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int RSEL_W = 2;
  localparam logic [RSEL_W-1:0] RS_ADDR  = 2'd0;
  localparam logic [RSEL_W-1:0] RS_COUNT = 2'd1;
  localparam logic [RSEL_W-1:0] RS_CTRL  = 2'd2;

  localparam int CB_START = 0;  // write: start, read: busy
  localparam int CB_DIR   = 1;  // 1: peripheral -> memory
  localparam int CB_MODE  = 2;  // 1: cycle stealing
  localparam int CB_DONE  = 3;  // write 1: clear, read: done

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_REL
  } dma_state_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [RSEL_W-1:0] cpu_rsel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_grant,
  input  logic              busy,
  input  logic              word_move,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dir_q,
  output logic              mode_q,
  output logic              done_q,
  output logic              start_pulse,
  output logic              last_word,
  output logic              count_zero
);
  logic [CNT_W-1:0] count_q;
  logic port_ok, wr_addr, wr_count, wr_ctrl, zero_start, set_done, clr_done;

  assign port_ok  = cpu_sel && !bus_grant;
  assign wr_addr  = port_ok && cpu_wr && cpu_rsel == RS_ADDR  && !busy;
  assign wr_count = port_ok && cpu_wr && cpu_rsel == RS_COUNT && !busy;
  assign wr_ctrl  = port_ok && cpu_wr && cpu_rsel == RS_CTRL;

  assign count_zero  = (count_q == '0);
  assign last_word   = (count_q == CNT_W'(1));
  assign start_pulse = wr_ctrl && !busy && cpu_wdata[CB_START] && !count_zero;
  assign zero_start  = wr_ctrl && !busy && cpu_wdata[CB_START] && count_zero;
  assign set_done    = zero_start || (word_move && last_word);
  assign clr_done    = wr_ctrl && cpu_wdata[CB_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (word_move) begin
        addr_q  <= addr_q + 1'b1;
        count_q <= count_q - 1'b1;
      end else begin
        if (wr_addr)  addr_q  <= cpu_wdata[ADDR_W-1:0];
        if (wr_count) count_q <= cpu_wdata[CNT_W-1:0];
      end
      if (wr_ctrl && !busy) begin
        dir_q  <= cpu_wdata[CB_DIR];
        mode_q <= cpu_wdata[CB_MODE];
      end
      if (set_done)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (port_ok) begin
      unique case (cpu_rsel)
        RS_ADDR:  cpu_rdata = DATA_W'(addr_q);
        RS_COUNT: cpu_rdata = DATA_W'(count_q);
        RS_CTRL: begin
          cpu_rdata[CB_START] = busy;
          cpu_rdata[CB_DIR]   = dir_q;
          cpu_rdata[CB_MODE]  = mode_q;
          cpu_rdata[CB_DONE]  = done_q;
        end
        default: cpu_rdata = '0;
      endcase
    end
  end

  // R5: one step of address and count per word
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_move |=> addr_q == $past(addr_q) + 1'b1);
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_move |=> count_q == $past(count_q) - 1'b1);
  // R2: granted port leaves the address alone
  a_r2_no_write_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !word_move) |=> $stable(addr_q));
  // R10: done persists until cleared
  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done) |=> done_q);
  // R9: zero-count start finishes at once
  a_r9_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> done_q);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic bus_grant,
  input  logic dma_req,
  input  logic steal_mode,
  input  logic last_word,
  input  logic count_zero,
  output logic bus_req,
  output logic word_move,
  output logic busy
);
  dma_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    bus_req   = 1'b0;
    word_move = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_pulse) state_d = ST_REQ;
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_grant) state_d = ST_XFER;
      end
      ST_XFER: begin
        bus_req   = 1'b1;
        word_move = bus_grant && dma_req;
        if (word_move && (last_word || steal_mode)) state_d = ST_REL;
      end
      ST_REL: begin
        if (!bus_grant) state_d = count_zero ? ST_IDLE : ST_REQ;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);

  // R4: the buses are touched only under grant
  a_r4_move_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    word_move |-> (bus_grant && dma_req));
  // R7: request dropped after each stolen word
  a_r7_steal_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_move && steal_mode) |=> !bus_req);
  // R8: request dropped after the final word
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (word_move && last_word) |=> !bus_req);
  // R7: no new request until the grant has gone
  a_r7_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_grant && busy) |=> !bus_req);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_rsel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              dma_req,
  output logic              dma_ack,
  input  logic [DATA_W-1:0] per_wdata,
  output logic [DATA_W-1:0] per_rdata,
  output logic              irq
);
  logic [ADDR_W-1:0] addr_q;
  logic dir_q, mode_q, done_q, start_pulse, last_word, count_zero;
  logic word_move, busy;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rsel(cpu_rsel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_grant(bus_grant), .busy(busy), .word_move(word_move),
    .addr_q(addr_q), .dir_q(dir_q), .mode_q(mode_q), .done_q(done_q),
    .start_pulse(start_pulse), .last_word(last_word), .count_zero(count_zero)
  );

  dma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_pulse(start_pulse), .bus_grant(bus_grant), .dma_req(dma_req),
    .steal_mode(mode_q), .last_word(last_word), .count_zero(count_zero),
    .bus_req(bus_req), .word_move(word_move), .busy(busy)
  );

  assign mem_addr  = bus_grant ? addr_q : '0;
  assign mem_wr    = word_move && dir_q;
  assign mem_rd    = word_move && !dir_q;
  assign mem_wdata = mem_wr ? per_wdata : '0;
  assign per_rdata = mem_rd ? mem_rdata : '0;
  assign dma_ack   = word_move;
  assign irq       = done_q;

  // R4: one strobe at a time, each paired with the handshake
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}) && ((mem_rd || mem_wr) == dma_ack));
  // R4: strobes only while granted
  a_r4_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_grant);
endmodule

// File: tb/dma_ctrl_test.sv
module dma_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0] cpu_rsel = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_grant = 1'b0;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata, per_wdata, per_rdata;
  logic dma_req, dma_ack, irq;

  int nchk = 0, nfail = 0;
  logic grant_en = 1'b1, force_grant = 1'b0;
  logic per_en = 1'b0, per_gappy = 1'b0;
  logic [DW-1:0] bmem [0:63];
  logic [DW-1:0] rx [0:15];
  int rx_n = 0, per_cnt = 0, cyc = 0;
  int ncyc = 0, viol = 0, gapviol = 0, falls = 0, rises = 0;
  int last_ack = 0, irq_rise = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_rsel(cpu_rsel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dma_req(dma_req), .dma_ack(dma_ack),
    .per_wdata(per_wdata), .per_rdata(per_rdata), .irq(irq)
  );

  // processor-side arbiter, memory and peripheral models
  always @(posedge clk) begin
    bus_grant <= force_grant | (bus_req & grant_en);
    cyc <= cyc + 1;
    if (mem_wr) bmem[mem_addr[5:0]] <= mem_wdata;
    if (dma_ack) begin
      per_cnt <= per_cnt + 1;
      rx[rx_n[3:0]] <= per_rdata;
      rx_n <= rx_n + 1;
    end
  end
  assign mem_rdata = bmem[mem_addr[5:0]];
  assign dma_req   = per_en & (!per_gappy | cyc[0]);
  assign per_wdata = 16'hA000 + DW'(per_cnt);

  // monitor, sampled mid-cycle
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if ((mem_rd || mem_wr || dma_ack) && !bus_grant) viol = viol + 1;
    if (prev_ack && bus_req) gapviol = gapviol + 1;
    if (prev_req && !bus_req) falls = falls + 1;
    if (!prev_req && bus_req) rises = rises + 1;
    if (dma_ack) last_ack = ncyc;
    if (irq && !prev_irq) irq_rise = ncyc;
    prev_req = bus_req; prev_ack = dma_ack; prev_irq = irq;
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic cpu_write(logic [1:0] rs, logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_rsel = rs; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(logic [1:0] rs, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_rsel = rs;
    #1 d = cpu_rdata;
    cpu_sel = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
    repeat (4) @(negedge clk);  // let the bus come back
  endtask

  task automatic clear_counters();
    viol = 0; gapviol = 0; falls = 0; rises = 0; rx_n = 0; per_cnt = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 strobes/ack", {mem_rd, mem_wr, dma_ack}, 0);
    for (int r = 0; r < 3; r++) begin
      cpu_read(2'(r), d);
      chk("R1 register reset", d, 0);
    end
  endtask

  task automatic t_zero_count();
    clear_counters();
    cpu_write(2'd1, 16'd0);
    cpu_write(2'd2, 16'h0001);
    chk("R9 irq after zero-count start", irq, 1);
    repeat (5) @(negedge clk);
    chk("R9 no bus request", rises, 0);
    cpu_write(2'd2, 16'h0008);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_burst_write();
    logic [DW-1:0] d;
    clear_counters();
    per_en = 1'b1; per_gappy = 1'b1;
    cpu_write(2'd0, 16'd8);
    cpu_write(2'd1, 16'd4);
    cpu_write(2'd2, 16'h0003);       // start, peripheral->memory, burst
    chk("R3 request next cycle", bus_req, 1);
    wait_irq();
    per_en = 1'b0;
    for (int i = 0; i < 4; i++) chk("R4 memory written", bmem[8+i], 16'hA000 + 16'(i));
    chk("R6 one tenure", falls, 1);
    chk("R8 irq one cycle after last word", irq_rise - last_ack, 1);
    chk("R4 no strobe without grant", viol, 0);
    cpu_read(2'd0, d); chk("R5 address advanced", d, 16'd12);
    cpu_read(2'd1, d); chk("R5 count exhausted", d, 16'd0);
    repeat (6) @(negedge clk);
    chk("R10 irq holds", irq, 1);
    cpu_write(2'd2, 16'h0008);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_steal_read();
    logic [DW-1:0] d;
    clear_counters();
    for (int i = 0; i < 3; i++) bmem[20+i] = 16'h5A00 + 16'(i);
    per_en = 1'b1; per_gappy = 1'b0;
    cpu_write(2'd0, 16'd20);
    cpu_write(2'd1, 16'd3);
    cpu_write(2'd2, 16'h0005);       // start, memory->peripheral, steal
    while (!dma_ack) @(negedge clk);
    @(negedge clk);
    cpu_write(2'd1, 16'd50);         // in the gap, still busy: dropped
    wait_irq();
    per_en = 1'b0;
    chk("R10 busy write ignored, words", rx_n, 3);
    for (int i = 0; i < 3; i++) chk("R4 peripheral got word", rx[i], 16'h5A00 + 16'(i));
    chk("R7 request dropped after each word", gapviol, 0);
    chk("R7 three tenures", falls, 3);
    chk("R4 no strobe without grant", viol, 0);
    cpu_read(2'd1, d); chk("R5 count exhausted", d, 16'd0);
    cpu_write(2'd2, 16'h0008);
  endtask

  task automatic t_grant_gate();
    logic [DW-1:0] d;
    cpu_write(2'd0, 16'd30);
    force_grant = 1'b1;
    @(negedge clk);
    cpu_read(2'd0, d); chk("R2 read while granted is 0", d, 0);
    cpu_write(2'd0, 16'd77);
    force_grant = 1'b0;
    repeat (2) @(negedge clk);
    cpu_read(2'd0, d); chk("R2 granted write dropped", d, 16'd30);
  endtask

  task automatic t_held_grant();
    clear_counters();
    grant_en = 1'b0; per_en = 1'b1; per_gappy = 1'b0;
    cpu_write(2'd0, 16'd40);
    cpu_write(2'd1, 16'd2);
    cpu_write(2'd2, 16'h0003);
    repeat (5) @(negedge clk);
    chk("R3 request held", bus_req, 1);
    chk("R3 no ack before grant", per_cnt, 0);
    chk("R3 no strobe before grant", viol, 0);
    grant_en = 1'b1;
    wait_irq();
    per_en = 1'b0;
    chk("R4 words after grant", bmem[41], 16'hA001);
    cpu_write(2'd2, 16'h0008);
  endtask

  task automatic t_collide();
    logic [DW-1:0] d;
    clear_counters();
    per_en = 1'b1; per_gappy = 1'b1;
    cpu_write(2'd0, 16'd48);
    cpu_write(2'd1, 16'd6);
    cpu_write(2'd2, 16'h0003);
    while (!dma_ack) @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_rsel = 2'd0; cpu_wdata = 16'd5;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
    wait_irq();
    per_en = 1'b0;
    cpu_read(2'd0, d); chk("R2 write during word move dropped", d, 16'd54);
    chk("R4 last word stored", bmem[53], 16'hA005);
    cpu_write(2'd2, 16'h0008);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_count();
    t_burst_write();
    t_steal_read();
    t_grant_gate();
    t_held_grant();
    t_collide();
    summary();
    $finish;
  end
endmodule